// File: doc/BRIEF.md
# Translation Unit Bring-Up Sequencer

This block runs the power-on sequence for a host-side address translation unit. A one-cycle pulse on `start_i` makes it raise the unit's initialisation request. It then samples the unit's "active" status at a fixed interval, up to a bounded number of times. The interval is a cycle count derived from the clock frequency and a microsecond parameter.

When the unit reports active, the sequencer performs three steps in a fixed order, one clock cycle apart. It first reports the power state and then issues the prefetch request. It then lets dynamic clock gating run by clearing four gate-disable bits. After that it polls a "prefetch complete" status with the same interval and the same bound. If the unit never becomes active, none of the later steps happen.

Each run ends with `done_o` and exactly one result flag: success, activation timeout or prefetch timeout. All control outputs keep their values until the next start. A start that arrives while a run is in progress has no effect.

Top module: `vmu_bringup`

## Requirements
- R1: After reset, `init_req_o`, `pwr_stat_o`, `pf_req_o`, `done_o`, `ok_o`, `to_act_o` and `to_pf_o` are 0, and `cg_dis_o` is 4'hF (all gating disabled).
- R2: A `start_i` pulse while idle sets `init_req_o` to 1 and clears `done_o`, `ok_o`, `to_act_o`, `to_pf_o` and `pwr_stat_o`. It also clears `pf_req_o` and sets `cg_dis_o` back to 4'hF. All of this takes effect on the sampling edge.
- R3: `active_i` is first sampled on the clock edge after the one that raised `init_req_o`. Later samples follow every GAP cycles, where GAP = CLK_HZ/1e6 * GAP_US. There are at most MAX_POLLS samples.
- R4: If `active_i` is low at all MAX_POLLS samples, `done_o` and `to_act_o` rise on the edge of the last sample. `pwr_stat_o` and `pf_req_o` stay 0 and `cg_dis_o` stays 4'hF. This is 1+(MAX_POLLS-1)*GAP cycles after the start edge.
- R5: On the edge where `active_i` is seen high, `pwr_stat_o` rises. `pf_req_o` rises one cycle later, and `cg_dis_o` goes to 0 one cycle after that. The bit map of `cg_dis_o` is: bit0 display clock read side, bit1 display clock return side, bit2 fabric clock read side, bit3 fabric clock return side.
- R6: `pf_done_i` is first sampled one cycle after `cg_dis_o` clears, then every GAP cycles, up to MAX_POLLS samples. When it is seen high, `done_o` and `ok_o` rise on that edge.
- R7: If `pf_done_i` is low at all MAX_POLLS samples, `done_o` and `to_pf_o` rise on the last sample edge. `pwr_stat_o` and `pf_req_o` stay 1 and `cg_dis_o` stays 0.
- R8: While `done_o` is 1, exactly one of `ok_o`, `to_act_o`, `to_pf_o` is 1. While `done_o` is 0, none of them is.
- R9: `start_i` is ignored while a run is in progress: the run's timing and results are unchanged.
- R10: After `done_o` rises, every output holds its value until the next `start_i`, whatever the status inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a bring-up run |
| active_i | input | 1 | Translation unit reports it is active |
| pf_done_i | input | 1 | Translation unit reports prefetch complete |
| init_req_o | output | 1 | Initialisation request |
| pwr_stat_o | output | 1 | Power-state indication to the unit |
| pf_req_o | output | 1 | Prefetch request |
| cg_dis_o | output | 4 | Clock-gate disable bits (map in R5) |
| done_o | output | 1 | Run finished |
| ok_o | output | 1 | Run finished with prefetch complete |
| to_act_o | output | 1 | Run ended waiting for activation |
| to_pf_o | output | 1 | Run ended waiting for prefetch completion |

## Verification
A wrong poll count or a wrong interval shifts the cycle on which `done_o` rises, so the bench measures that latency exactly. The check runs for both phases, at the first and the last allowed sample. A misordered or skipped step shows up as wrong values of `pwr_stat_o`, `pf_req_o` or `cg_dis_o` once the run ends. The embedded properties catch such an error one cycle after the step itself. A state register that leaks past the end of a run shows up within a few cycles as an output change during the hold window, or as a stale flag after the next start.

// File: rtl/vmu_seq_pkg.sv
package vmu_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACT_SMP = 3'd1,
    ST_ACT_GAP = 3'd2,
    ST_PF_REQ  = 3'd3,
    ST_CG_EN   = 3'd4,
    ST_PF_SMP  = 3'd5,
    ST_PF_GAP  = 3'd6
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_START  = 3'd1,
    CMD_PWR    = 3'd2,
    CMD_PFREQ  = 3'd3,
    CMD_CG_EN  = 3'd4,
    CMD_OK     = 3'd5,
    CMD_TO_ACT = 3'd6,
    CMD_TO_PF  = 3'd7
  } seq_cmd_e;

endpackage

// File: rtl/vmu_gap_timer.sv
module vmu_gap_timer #(
  parameter int GAP_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(GAP_CYC - 2);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i | (run_i & ~expired_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = RELOAD;
    else if (run_i && !expired_o)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // A reload never coincides with a running wait (R3 spacing).
  assert_no_reload_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> !load_i);

endmodule

// File: rtl/vmu_poll_counter.sv
module vmu_poll_counter #(
  parameter int MAX_POLLS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last_o = (cnt_q == LAST);
  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (inc_i)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // The controller never asks for a sample beyond the bound.
  assert_poll_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !last_o);

endmodule

// File: rtl/vmu_seq_fsm.sv
module vmu_seq_fsm
  import vmu_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     active_i,
  input  logic     pf_done_i,
  input  logic     gap_expired_i,
  input  logic     poll_last_i,
  output logic     gap_load_o,
  output logic     gap_run_o,
  output logic     poll_clr_o,
  output logic     poll_inc_o,
  output seq_cmd_e cmd_o,
  output logic     busy_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cmd_o      = CMD_NONE;
    gap_load_o = 1'b0;
    gap_run_o  = 1'b0;
    poll_clr_o = 1'b0;
    poll_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cmd_o      = CMD_START;
          poll_clr_o = 1'b1;
          state_d    = ST_ACT_SMP;
        end
      end
      ST_ACT_SMP: begin
        if (active_i) begin
          cmd_o   = CMD_PWR;
          state_d = ST_PF_REQ;
        end else if (poll_last_i) begin
          cmd_o   = CMD_TO_ACT;
          state_d = ST_IDLE;
        end else begin
          poll_inc_o = 1'b1;
          gap_load_o = 1'b1;
          state_d    = ST_ACT_GAP;
        end
      end
      ST_ACT_GAP: begin
        gap_run_o = 1'b1;
        if (gap_expired_i) state_d = ST_ACT_SMP;
      end
      ST_PF_REQ: begin
        cmd_o   = CMD_PFREQ;
        state_d = ST_CG_EN;
      end
      ST_CG_EN: begin
        cmd_o      = CMD_CG_EN;
        poll_clr_o = 1'b1;
        state_d    = ST_PF_SMP;
      end
      ST_PF_SMP: begin
        if (pf_done_i) begin
          cmd_o   = CMD_OK;
          state_d = ST_IDLE;
        end else if (poll_last_i) begin
          cmd_o   = CMD_TO_PF;
          state_d = ST_IDLE;
        end else begin
          poll_inc_o = 1'b1;
          gap_load_o = 1'b1;
          state_d    = ST_PF_GAP;
        end
      end
      ST_PF_GAP: begin
        gap_run_o = 1'b1;
        if (gap_expired_i) state_d = ST_PF_SMP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);

  // A start seen while busy produces no start command.
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cmd_o != CMD_START));

endmodule

// File: rtl/vmu_ctl_regs.sv
module vmu_ctl_regs
  import vmu_seq_pkg::*;
#(
  parameter int CG_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_cmd_e        cmd_i,
  input  logic            start_i,
  output logic            init_req_o,
  output logic            pwr_stat_o,
  output logic            pf_req_o,
  output logic [CG_W-1:0] cg_dis_o,
  output logic            done_o,
  output logic            ok_o,
  output logic            to_act_o,
  output logic            to_pf_o
);
  logic en_start, en_pwr, en_pf, en_cg, en_fin;
  logic fin_ok, fin_act, fin_pf;

  assign en_start = (cmd_i == CMD_START);
  assign en_pwr   = (cmd_i == CMD_PWR);
  assign en_pf    = (cmd_i == CMD_PFREQ);
  assign en_cg    = (cmd_i == CMD_CG_EN);
  assign fin_ok   = (cmd_i == CMD_OK);
  assign fin_act  = (cmd_i == CMD_TO_ACT);
  assign fin_pf   = (cmd_i == CMD_TO_PF);
  assign en_fin   = fin_ok | fin_act | fin_pf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req_o <= 1'b0;
      pwr_stat_o <= 1'b0;
      pf_req_o   <= 1'b0;
      cg_dis_o   <= '1;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      to_act_o   <= 1'b0;
      to_pf_o    <= 1'b0;
    end else begin
      if (en_start) begin
        init_req_o <= 1'b1;
        pwr_stat_o <= 1'b0;
        pf_req_o   <= 1'b0;
        cg_dis_o   <= '1;
      end
      if (en_pwr) pwr_stat_o <= 1'b1;
      if (en_pf)  pf_req_o   <= 1'b1;
      if (en_cg)  cg_dis_o   <= '0;
      if (en_start || en_fin) begin
        done_o   <= en_fin;
        ok_o     <= fin_ok;
        to_act_o <= fin_act;
        to_pf_o  <= fin_pf;
      end
    end
  end

  assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({ok_o, to_act_o, to_pf_o}) == 1));

  assert_no_result_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ({ok_o, to_act_o, to_pf_o} == 3'b000));

  assert_pwr_before_pf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_req_o) |-> (pwr_stat_o && $past(pwr_stat_o)));

  assert_cg_after_pf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cg_dis_o[0]) |-> $past(pf_req_o));

  assert_pwr_needs_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_stat_o) |-> init_req_o);

  assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable({init_req_o, pwr_stat_o, pf_req_o, cg_dis_o,
                                      done_o, ok_o, to_act_o, to_pf_o}));

endmodule

// File: rtl/vmu_bringup.sv
module vmu_bringup
  import vmu_seq_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int GAP_US    = 5,
  parameter int MAX_POLLS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       active_i,
  input  logic       pf_done_i,
  output logic       init_req_o,
  output logic       pwr_stat_o,
  output logic       pf_req_o,
  output logic [3:0] cg_dis_o,
  output logic       done_o,
  output logic       ok_o,
  output logic       to_act_o,
  output logic       to_pf_o
);
  localparam int GAP_CYC = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int CG_W    = 4;

  logic     gap_load, gap_run, gap_expired;
  logic     poll_clr, poll_inc, poll_last;
  logic     busy;
  seq_cmd_e cmd;

  vmu_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (gap_load),
    .run_i     (gap_run),
    .expired_o (gap_expired)
  );

  vmu_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  vmu_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .active_i      (active_i),
    .pf_done_i     (pf_done_i),
    .gap_expired_i (gap_expired),
    .poll_last_i   (poll_last),
    .gap_load_o    (gap_load),
    .gap_run_o     (gap_run),
    .poll_clr_o    (poll_clr),
    .poll_inc_o    (poll_inc),
    .cmd_o         (cmd),
    .busy_o        (busy)
  );

  vmu_ctl_regs #(.CG_W(CG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .start_i    (start_i),
    .init_req_o (init_req_o),
    .pwr_stat_o (pwr_stat_o),
    .pf_req_o   (pf_req_o),
    .cg_dis_o   (cg_dis_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .to_act_o   (to_act_o),
    .to_pf_o    (to_pf_o)
  );

  initial begin
    assert_param_gap_R3: assert (GAP_CYC >= 2);
    assert_param_polls_R3: assert (MAX_POLLS >= 2);
  end

  // No finishing result while still running a phase.
  assert_done_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(done_o)) |-> !done_o || !busy);

endmodule

// File: tb/sim_vmu_bringup.sv
module sim_vmu_bringup;
  localparam int CLK_HZ = 50_000_000;
  localparam int GAP_US = 1;
  localparam int M      = 6;
  localparam int G      = (CLK_HZ / 1_000_000) * GAP_US;

  typedef struct {
    int         lat;
    logic       ok, ta, tp, init, pwr, pf;
    logic [3:0] cg;
  } exp_t;

  logic clk, rst_n, start_i, active_i, pf_done_i;
  logic init_req_o, pwr_stat_o, pf_req_o, done_o, ok_o, to_act_o, to_pf_o;
  logic [3:0] cg_dis_o;

  int checks = 0, fails = 0;
  int cyc = 0, k_cyc = 0;
  exp_t q[$];
  logic prev_done = 1'b0;

  vmu_bringup #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US), .MAX_POLLS(M)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .active_i(active_i),
    .pf_done_i(pf_done_i), .init_req_o(init_req_o), .pwr_stat_o(pwr_stat_o),
    .pf_req_o(pf_req_o), .cg_dis_o(cg_dis_o), .done_o(done_o), .ok_o(ok_o),
    .to_act_o(to_act_o), .to_pf_o(to_pf_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: pops the expected result when done rises.
  always @(negedge clk) begin
    if (rst_n && done_o && !prev_done) begin
      if (q.size() == 0) begin
        chk("R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R3/R4/R6 done latency", cyc - k_cyc, e.lat);
        chk("R6 ok", ok_o, e.ok);
        chk("R4 act timeout", to_act_o, e.ta);
        chk("R7 pf timeout", to_pf_o, e.tp);
        chk("R2 init_req", init_req_o, e.init);
        chk("R5 pwr_stat", pwr_stat_o, e.pwr);
        chk("R5 pf_req", pf_req_o, e.pf);
        chk("R5 cg_dis", cg_dis_o, e.cg);
      end
    end
    prev_done <= done_o;
  end

  // Driver: act_at / pf_at are sample indices, -1 means never.
  task automatic run_seq(input int act_at, input int pf_at, input bit extra_start);
    exp_t e;
    int rel = 0;
    e.init = 1'b1;
    if (act_at < 0) begin
      e.lat = 1 + (M - 1) * G; e.ok = 0; e.ta = 1; e.tp = 0;
      e.pwr = 0; e.pf = 0; e.cg = 4'hF;
    end else if (pf_at < 0) begin
      e.lat = 1 + act_at * G + 3 + (M - 1) * G; e.ok = 0; e.ta = 0; e.tp = 1;
      e.pwr = 1; e.pf = 1; e.cg = 4'h0;
    end else begin
      e.lat = 1 + act_at * G + 3 + pf_at * G; e.ok = 1; e.ta = 0; e.tp = 0;
      e.pwr = 1; e.pf = 1; e.cg = 4'h0;
    end
    @(negedge clk);
    start_i = 1'b1; active_i = 1'b0; pf_done_i = 1'b0;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    k_cyc = cyc;
    chk("R2 init_req after start", init_req_o, 1);
    chk("R2 done cleared", done_o, 0);
    chk("R2 flags cleared", {ok_o, to_act_o, to_pf_o, pwr_stat_o, pf_req_o}, 0);
    chk("R2 cg restored", cg_dis_o, 4'hF);
    while (!done_o && rel < 20000) begin
      active_i  = (act_at >= 0) && (rel >= act_at * G);
      pf_done_i = (act_at >= 0) && (pf_at >= 0) && (rel >= act_at * G + 3 + pf_at * G);
      start_i   = extra_start && (rel == G || rel == G + 7); // R9 ignored starts
      @(negedge clk);
      rel++;
    end
    start_i = 1'b0;
    if (!done_o) chk("R8 run never finished", 0, 1);
    // R10: toggle status inputs, outputs must hold.
    for (int i = 0; i < 12; i++) begin
      active_i = i[0]; pf_done_i = i[1];
      @(negedge clk);
    end
    chk("R10 hold done", done_o, 1);
    chk("R10 hold ok", ok_o, e.ok);
    chk("R10 hold to_act", to_act_o, e.ta);
    chk("R10 hold to_pf", to_pf_o, e.tp);
    chk("R10 hold pwr", pwr_stat_o, e.pwr);
    chk("R10 hold pf", pf_req_o, e.pf);
    chk("R10 hold cg", cg_dis_o, e.cg);
    active_i = 1'b0; pf_done_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    start_i = 1'b0; active_i = 1'b0; pf_done_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 init_req", init_req_o, 0);
    chk("R1 pwr/pf", {pwr_stat_o, pf_req_o}, 0);
    chk("R1 cg_dis", cg_dis_o, 4'hF);
    chk("R1 done/flags", {done_o, ok_o, to_act_o, to_pf_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_seq(0, 0, 1'b0);       // R5 R6 fastest path
    run_seq(2, 3, 1'b0);       // R3 R6 mid-window
    run_seq(-1, -1, 1'b0);     // R4 never active
    run_seq(1, -1, 1'b0);      // R7 prefetch timeout
    run_seq(M - 1, M - 1, 1'b0); // R3 R6 last allowed samples
    run_seq(2, 1, 1'b1);       // R9 starts during run
    run_seq(0, 2, 1'b0);       // R10 restart clears flags
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule